// File: doc/BRIEF.md
# Quasi-Bidirectional Port

This block models one general-purpose I/O port of a small microcontroller, seen from the on-chip register bus. Each pin has an output latch. A 0 in the latch turns on a pull-down that forces the pin low. A 1 turns the pull-down off, so a weak pull-up sets the idle level. The pin is then free to act as an input, or to carry a peripheral's alternate output. The live pin level passes through a synchronizer. It then feeds the register read path and the per-pin alternate inputs, such as serial receive, interrupt and timer inputs.

Which value a read returns depends on the access type. A read-modify-write access returns the latch contents, so an AND or OR with a constant changes only the bits it means to change. Any other read returns the synchronized pin level. The register bus uses single-cycle strobes and has no back-pressure. A write lands on the clock edge where the write strobe and the port's address are both present. Read data is combinational and is zero unless this port is being read, so several ports can share one OR-ed read bus.

A narrower variant is made by lowering the count of live bits. The pins above that count always read 1, ignore writes and are never pulled down.

Top module: `qbio_port`

## Requirements
- R1: After reset every latch bit is 1, no pull-down is enabled, and both read types return all ones.
- R2: A write loads `sfr_wdata` into the latch at the rising edge where `sfr_wr` is 1 and `sfr_addr` equals `SFR_ADDR`. A write to any other address leaves the latch unchanged.
- R3: A live bit whose latch holds 0 has `pad_pd_en` = 1, whatever its alternate output is.
- R4: A live bit whose latch holds 1 has `pad_pd_en` equal to the inverse of its `alt_out` bit. A peripheral can only pull the pin low through a latch holding 1.
- R5: With `sfr_rd`=1, the address matching and `sfr_rmw`=1, `sfr_rdata` returns the latch contents, not the pin level.
- R6: With `sfr_rd`=1, the address matching and `sfr_rmw`=0, `sfr_rdata` returns `pad_in` as sampled two rising edges earlier (a two-flop synchronizer).
- R7: `alt_in` carries the same synchronized pin level as the R6 read path.
- R8: `sfr_rdata` is 0 whenever `sfr_rd` is 0 or `sfr_addr` differs from `SFR_ADDR`.
- R9: Bits at or above `LIVE_W` read 1 on both read types and on `alt_in`, ignore writes, and never assert `pad_pd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | ADDR_W | Register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | W | Write data |
| sfr_rd | input | 1 | Read strobe |
| sfr_rmw | input | 1 | 1 = read-modify-write access (returns the latch) |
| sfr_rdata | output | W | Read data, 0 when this port is not being read |
| alt_out | input | W | Peripheral output per pin, 1 = release |
| alt_in | output | W | Synchronized pin level for peripherals |
| pad_in | input | W | Level observed on the pad |
| pad_pd_en | output | W | Pull-down enable per pad, 1 = pin pulled low |

## Verification
The bench builds two instances on one shared register bus. The first is a full 8-bit port at address B0h with all bits live. The second is a 4-bit variant at D8h with `LIVE_W`=4. The pair makes address decoding testable in both directions: each port ignores writes meant for the other. The narrow instance brings the rule for unused upper bits within reach. A pad model combines each pull-down with an external driver, so pins can be held low from outside while the latch holds 1. That is the case where a read-modify-write read and a plain read must differ.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

  typedef enum logic {
    SRC_PIN   = 1'b0,
    SRC_LATCH = 1'b1
  } rd_src_e;

  // Mask with the lowest n bits set (n up to 64).
  function automatic logic [63:0] low_ones(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/qbio_latch.sv
module qbio_latch #(
  parameter int W      = 8,
  parameter int LIVE_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q
);
  localparam logic [W-1:0] LIVE_M = W'(qbio_pkg::low_ones(LIVE_W));

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < LIVE_W) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      latch_q[i] <= 1'b1;
        else if (wr_hit) latch_q[i] <= wdata[i];
      end
    end else begin : g_unused
      assign latch_q[i] = 1'b1;
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> latch_q == ($past(wdata) | ~LIVE_M));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(latch_q));
  a_r9_unused_one: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q | LIVE_M) == {W{1'b1}});

endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= '0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
    end
    a_r6_two_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2) |-> dout == $past(din, 2));
  end

endmodule

// File: rtl/qbio_rdmux.sv
module qbio_rdmux #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  qbio_pkg::rd_src_e src,
  input  logic [W-1:0]      latch_q,
  input  logic [W-1:0]      pin_q,
  output logic [W-1:0]      rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) rdata = (src == qbio_pkg::SRC_LATCH) ? latch_q : pin_q;
  end

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);

endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int              W        = 8,
  parameter int              LIVE_W   = 8,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'hB0,
  parameter int              SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [W-1:0]      sfr_wdata,
  input  logic              sfr_rd,
  input  logic              sfr_rmw,
  output logic [W-1:0]      sfr_rdata,
  input  logic [W-1:0]      alt_out,
  output logic [W-1:0]      alt_in,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_pd_en
);
  localparam logic [W-1:0] LIVE_M = W'(qbio_pkg::low_ones(LIVE_W));

  logic              hit, wr_hit, rd_en;
  logic [W-1:0]      latch_q, pin_q;
  qbio_pkg::rd_src_e src;

  assign hit    = (sfr_addr == SFR_ADDR);
  assign wr_hit = sfr_wr & hit;
  assign rd_en  = sfr_rd & hit;
  assign src    = sfr_rmw ? qbio_pkg::SRC_LATCH : qbio_pkg::SRC_PIN;

  qbio_latch #(.W(W), .LIVE_W(LIVE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(sfr_wdata), .latch_q(latch_q)
  );

  // Pull-down: on unless both the latch and the peripheral release the pin.
  assign pad_pd_en = ~(latch_q & alt_out) & LIVE_M;

  qbio_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in | ~LIVE_M), .dout(pin_q)
  );

  assign alt_in = pin_q;

  qbio_rdmux #(.W(W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .src(src),
    .latch_q(latch_q), .pin_q(pin_q), .rdata(sfr_rdata)
  );

  a_r3_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((~latch_q & LIVE_M) & ~pad_pd_en) == '0);
  a_r4_alt_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_q & LIVE_M) & (pad_pd_en ^ ~alt_out)) == '0);
  a_r9_no_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pd_en & ~LIVE_M) == '0);
  a_r7_alt_in: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sfr_rmw) |-> sfr_rdata == alt_in);

endmodule

// File: tb/test_qbio_port.sv
module test_qbio_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_FULL = 8'hB0;
  localparam logic [7:0] A_NAR  = 8'hD8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, alt = 8'hFF, ext = 8'hFF;
  logic       wr = 1'b0, rd = 1'b0, rmw = 1'b0;
  logic [7:0] rd_f, rd_n, ain_f, ain_n, pd_f, pd_n, pad_f, pad_n;
  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pad_f = ~pd_f & ext;
  assign pad_n = ~pd_n & ext;

  qbio_port #(.W(8), .LIVE_W(8), .ADDR_W(8), .SFR_ADDR(A_FULL)) i_qbio_port (
    .clk(clk), .rst_n(rst_n), .sfr_addr(addr), .sfr_wr(wr), .sfr_wdata(wdata),
    .sfr_rd(rd), .sfr_rmw(rmw), .sfr_rdata(rd_f), .alt_out(alt), .alt_in(ain_f),
    .pad_in(pad_f), .pad_pd_en(pd_f)
  );

  qbio_port #(.W(8), .LIVE_W(4), .ADDR_W(8), .SFR_ADDR(A_NAR)) i_qbio_port_nar (
    .clk(clk), .rst_n(rst_n), .sfr_addr(addr), .sfr_wr(wr), .sfr_wdata(wdata),
    .sfr_rd(rd), .sfr_rmw(rmw), .sfr_rdata(rd_n), .alt_out(8'hFF), .alt_in(ain_n),
    .pad_in(pad_n), .pad_pd_en(pd_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_port(input logic [7:0] a, input logic m,
                         output logic [7:0] df, output logic [7:0] dn);
    addr = a; rmw = m; rd = 1'b1;
    #1;
    df = rd_f; dn = rd_n;
    rd = 1'b0; rmw = 1'b0;
  endtask

  // {write data, alt_out, external level, expected pull-down, expected pin}
  typedef struct packed {
    logic [7:0] w, a, e, pd, pin;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF},
    '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00},
    '{8'hF0, 8'hFF, 8'hFF, 8'h0F, 8'hF0},
    '{8'hFF, 8'h0F, 8'hFF, 8'hF0, 8'h0F},
    '{8'hFF, 8'hFF, 8'h3C, 8'h00, 8'h3C},
    '{8'hA5, 8'hF0, 8'hFF, 8'h5F, 8'hA0},
    '{8'h5A, 8'hFF, 8'hC3, 8'hA5, 8'h42}
  };

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] df, dn;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pull-down after reset", pd_f, 8'h00);
    rd_port(A_FULL, 1'b1, df, dn);
    chk("R1 latch read after reset", df, 8'hFF);
    rd_port(A_FULL, 1'b0, df, dn);
    chk("R1 pin read after reset", df, 8'hFF);

    // Table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      alt = VECS[i].a; ext = VECS[i].e;
      wr_port(A_FULL, VECS[i].w);
      chk("R3/R4 pull-down", pd_f, VECS[i].pd);
      repeat (2) @(negedge clk);
      rd_port(A_FULL, 1'b1, df, dn);
      chk("R2/R5 latch read", df, VECS[i].w);
      rd_port(A_FULL, 1'b0, df, dn);
      chk("R6 pin read", df, VECS[i].pin);
      chk("R7 alt input", ain_f, VECS[i].pin);
    end

    // R6 synchronizer latency: pin read lags by two edges
    alt = 8'hFF; ext = 8'hFF;
    wr_port(A_FULL, 8'h00);
    repeat (2) @(negedge clk);
    wr_port(A_FULL, 8'hFF);
    rd_port(A_FULL, 1'b0, df, dn);
    chk("R6 lag edge1", df, 8'h00);
    @(negedge clk);
    rd_port(A_FULL, 1'b0, df, dn);
    chk("R6 lag edge2", df, 8'h00);
    @(negedge clk);
    rd_port(A_FULL, 1'b0, df, dn);
    chk("R6 after edge3", df, 8'hFF);

    // R5 latch read vs pin read when pins held low externally
    ext = 8'h00;
    repeat (3) @(negedge clk);
    rd_port(A_FULL, 1'b1, df, dn);
    chk("R5 latch unaffected by pins", df, 8'hFF);
    rd_port(A_FULL, 1'b0, df, dn);
    chk("R6 pin read held low", df, 8'h00);
    ext = 8'hFF;

    // R9 narrow variant, R2 cross-address writes
    wr_port(A_NAR, 8'h00);
    rd_port(A_NAR, 1'b1, dn, dn);
    chk("R9 narrow latch read", dn, 8'hF0);
    chk("R9 narrow pull-down", pd_n, 8'h0F);
    rd_port(A_FULL, 1'b1, df, dn);
    chk("R2 full ignores other address", df, 8'hFF);
    repeat (2) @(negedge clk);
    rd_port(A_NAR, 1'b0, df, dn);
    chk("R9 narrow pin read", dn, 8'hF0);
    chk("R9 narrow alt input", ain_n, 8'hF0);
    wr_port(A_NAR, 8'hFF);
    wr_port(A_FULL, 8'h00);
    rd_port(A_NAR, 1'b1, df, dn);
    chk("R2 narrow ignores other address", dn, 8'hFF);
    chk("R9 narrow upper never pulled", pd_n, 8'h00);

    // R8 read data quiet
    rd = 1'b0; addr = A_FULL; #1;
    chk("R8 no strobe", rd_f, 8'h00);
    rd_port(8'h80, 1'b1, df, dn);
    chk("R8 wrong address full", df, 8'h00);
    chk("R8 wrong address narrow", dn, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule